// File: doc/BRIEF.md
# Buffered-Duty PWM Channel Group

This block holds four independent pulse-width channels that share one clock, one reset, one count-enable input and one word-wide register port. Each channel has a free-running up-counter, a period register and a duty buffer that software writes. It also has a duty register that software cannot see. A channel reaches its period match when its counter equals its period register while counting is enabled. On that clock the channel clears its counter, raises a sticky match flag, and copies the buffer into the duty register. The same clock also starts the next output pulse.

Software can change the duty buffer at any time, and the change takes effect only at the following period match. A pulse therefore never changes shape partway through. A buffer value of zero holds the output low for a whole period. Within a period the output falls on the clock where the counter equals the duty register, and it stays low until the next match. Match flags are cleared by a read-then-write handshake. A new match arriving in the same clock as the clear keeps its flag.

Top module: `pwm_quad_group`

## Requirements
- R1: After reset, every period register and every duty buffer reads 0xFFFF, every internal duty register holds 0xFFFF, every counter is 0, every output is 0 and every flag is 0.
- R2: The period register of channel k (k = 0..3) is at address k and the duty buffer of channel k is at address 4+k, each 16 bits, readable and writable. The flag register is at address 8, with bit k for channel k and bits 15:4 reading 0. Any other address reads 0. Read data is valid in the same cycle as the address.
- R3: A write to a period register or a duty buffer takes effect only when both byte enables (bus_be = 2'b11) are set. With any other byte-enable value the register keeps its old contents.
- R4: A counter advances by one on each clock edge where cnt_run is 1 and holds its value while cnt_run is 0.
- R5: On an edge where cnt_run is 1 and a counter equals its period register, that counter becomes 0 and the channel's flag becomes 1.
- R6: On that same match edge, the duty buffer is copied into the duty register. Buffer writes made between matches do not change the current period's output. A write on the match edge itself is not taken until the next match.
- R7: On a match edge the output becomes 1 if the buffer value is nonzero and 0 if it is 0x0000. A zero buffer keeps the output low for the whole following period.
- R8: On an edge with cnt_run at 1 and no match, the output becomes 0 if the counter equals the duty register. The output stays 0 until the next match. After a match with buffer value d and period value p, the output is high for min(d+1, p+1) clocks of the p+1 clock period.
- R9: A flag bit clears only when a write to address 8 with bus_be[0] set carries 0 in that bit, and the flag register was read with that bit at 1 since the last write to address 8. Writing 1, or writing 0 without such a read, leaves the flag at 1.
- R10: If a match and a valid clear of the same flag fall on the same edge, the flag stays 1.
- R11: The channels are independent. Each one counts, matches and drives its output from its own registers only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_run | input | 1 | Count enable shared by all four counters |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_be | input | 2 | Byte enables, bit 1 = high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Registered pulse output, bit k = channel k |

## Verification
Register writes and flag updates become visible on the rising edge where the strobe is sampled. Read data follows the address in the same cycle. A match on edge n shows on the output, the flag and the cleared counter right after edge n. A duty compare on edge n lowers the output after that edge. Stimulus is driven on falling edges and sampled on falling edges, so every expected value is counted in whole edges from a known starting point. These include the ten clocks to the first match for a period of 9 and the duty-plus-one high time. A cycle-level reference built from the requirements runs beside the design, and the output is compared against it on every falling edge of the long runs.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

  typedef enum logic [1:0] {
    RK_PERIOD = 2'd0,
    RK_BUFFER = 2'd1,
    RK_FLAGS  = 2'd2,
    RK_NONE   = 2'd3
  } reg_kind_e;

  // Map an address onto the register kind for a group of n channels
  function automatic reg_kind_e kind_of(input int unsigned a, input int unsigned n);
    if (a < n)           return RK_PERIOD;
    else if (a < 2 * n)  return RK_BUFFER;
    else if (a == 2 * n) return RK_FLAGS;
    return RK_NONE;
  endfunction

  // Channel slot addressed inside its register kind
  function automatic int unsigned slot_of(input int unsigned a, input int unsigned n);
    if (a < n)     return a;
    if (a < 2 * n) return a - n;
    return 0;
  endfunction

endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_grp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [CW/8-1:0]          bus_be,
  input  logic [CW-1:0]            bus_wdata,
  input  logic [NCH-1:0]           match_evt,
  output logic [NCH-1:0][CW-1:0]   cyc_o,
  output logic [NCH-1:0][CW-1:0]   buf_o,
  output logic [NCH-1:0]           flag_o,
  output logic [CW-1:0]            bus_rdata
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  reg_kind_e        kind;
  logic [IW-1:0]    idx;
  logic             wr_full;
  logic             flag_wr;
  logic             flag_rd;
  logic [NCH-1:0]   arm_q;
  logic [NCH-1:0]   flag_q;
  logic [NCH-1:0]   clr_req;

  always_comb begin
    kind    = kind_of(int'(bus_addr), NCH);
    idx     = IW'(slot_of(int'(bus_addr), NCH));
    wr_full = bus_sel && bus_wr && (&bus_be);
    flag_wr = bus_sel && bus_wr && bus_be[0] && (kind == RK_FLAGS);
    flag_rd = bus_sel && !bus_wr && (kind == RK_FLAGS);
    clr_req = flag_wr ? (arm_q & ~bus_wdata[NCH-1:0]) : '0;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_slot
    logic [CW-1:0] cyc_r;
    logic [CW-1:0] buf_r;
    logic          hit_cyc;
    logic          hit_buf;
    assign hit_cyc = wr_full && (kind == RK_PERIOD) && (idx == IW'(k));
    assign hit_buf = wr_full && (kind == RK_BUFFER) && (idx == IW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cyc_r <= '1;
        buf_r <= '1;
      end else begin
        if (hit_cyc) cyc_r <= bus_wdata;
        if (hit_buf) buf_r <= bus_wdata;
      end
    end
    assign cyc_o[k] = cyc_r;
    assign buf_o[k] = buf_r;
  end

  // New matches override a clear landing on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_req) | match_evt;
      if (flag_rd)      arm_q <= flag_q;
      else if (flag_wr) arm_q <= '0;
    end
  end

  assign flag_o = flag_q;

  always_comb begin
    unique case (kind)
      RK_PERIOD: bus_rdata = cyc_o[idx];
      RK_BUFFER: bus_rdata = buf_o[idx];
      RK_FLAGS:  bus_rdata = {{(CW-NCH){1'b0}}, flag_q};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cyc,
  input  logic [CW-1:0] bufv,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] duty_o,
  output logic          match_o,
  output logic          pwm_o
);

  function automatic logic [CW-1:0] step(input logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  function automatic logic level_for(input logic [CW-1:0] b);
    return |b;
  endfunction

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] duty_q;
  logic          pwm_q;
  logic          hit_duty;

  assign match_o  = run && (cnt_q == cyc);
  assign hit_duty = run && (cnt_q == duty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '1;
      pwm_q  <= 1'b0;
    end else if (match_o) begin
      cnt_q  <= '0;
      duty_q <= bufv;
      pwm_q  <= level_for(bufv);
    end else begin
      if (run)      cnt_q <= step(cnt_q);
      if (hit_duty) pwm_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign pwm_o  = pwm_q;

endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_run,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW/8-1:0] bus_be,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  output logic [NCH-1:0]  pwm_out
);

  logic [NCH-1:0][CW-1:0] cyc_q;
  logic [NCH-1:0][CW-1:0] buf_q;
  logic [NCH-1:0][CW-1:0] cnt_q;
  logic [NCH-1:0][CW-1:0] duty_q;
  logic [NCH-1:0]         match_evt;
  logic [NCH-1:0]         flag_q;

  pwm_regbank #(.NCH(NCH), .CW(CW), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .match_evt (match_evt),
    .cyc_o     (cyc_q),
    .buf_o     (buf_q),
    .flag_o    (flag_q),
    .bus_rdata (bus_rdata)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    pwm_channel #(.CW(CW)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cnt_run),
      .cyc     (cyc_q[k]),
      .bufv    (buf_q[k]),
      .cnt_o   (cnt_q[k]),
      .duty_o  (duty_q[k]),
      .match_o (match_evt[k]),
      .pwm_o   (pwm_out[k])
    );
  end

endmodule

// File: rtl/pwm_quad_group_chk.sv
module pwm_quad_group_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cnt_run,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [CW/8-1:0]        bus_be,
  input logic [NCH-1:0]         match_evt,
  input logic [NCH-1:0][CW-1:0] cnt_q,
  input logic [NCH-1:0][CW-1:0] duty_q,
  input logic [NCH-1:0][CW-1:0] cyc_q,
  input logic [NCH-1:0][CW-1:0] buf_q,
  input logic [NCH-1:0]         flag_q,
  input logic [NCH-1:0]         pwm_out
);

  assert_partial_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !(&bus_be) && (bus_addr < AW'(2 * NCH)))
      |=> ($stable(cyc_q) && $stable(buf_q)));

  for (genvar k = 0; k < NCH; k++) begin : g_prop
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_run |=> $stable(cnt_q[k]));

    assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[k] |=> (cnt_q[k] == '0));

    assert_match_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[k] |=> flag_q[k]);

    assert_duty_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[k] |=> (duty_q[k] == $past(buf_q[k])));

    assert_level_at_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[k] |=> (pwm_out[k] == ($past(buf_q[k]) != '0)));

    assert_falls_at_duty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_run && (cnt_q[k] == duty_q[k]) && !match_evt[k]) |=> !pwm_out[k]);

    assert_low_until_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_out[k] && !match_evt[k]) |=> !pwm_out[k]);

    assert_clear_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[k]) |-> $past(bus_sel && bus_wr));
  end

endmodule

bind pwm_quad_group pwm_quad_group_chk #(.NCH(NCH), .CW(CW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_run   (cnt_run),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .match_evt (match_evt),
  .cnt_q     (cnt_q),
  .duty_q    (duty_q),
  .cyc_q     (cyc_q),
  .buf_q     (buf_q),
  .flag_q    (flag_q),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_quad_group_tb_top.sv
module pwm_quad_group_tb_top;

  localparam int NCH = 4;
  localparam logic [3:0] A_FLAGS = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_run = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_quad_group dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_run   (cnt_run),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  // Cycle-level reference written from the requirements
  logic [15:0] m_cyc [NCH];
  logic [15:0] m_buf [NCH];
  logic [15:0] m_duty[NCH];
  logic [15:0] m_cnt [NCH];
  logic        m_out [NCH];
  logic        m_flag[NCH];
  logic        m_arm [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_cyc[i] <= 16'hFFFF; m_buf[i] <= 16'hFFFF; m_duty[i] <= 16'hFFFF;
        m_cnt[i] <= 16'h0; m_out[i] <= 1'b0; m_flag[i] <= 1'b0; m_arm[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        automatic bit hit = cnt_run && (m_cnt[i] == m_cyc[i]);
        automatic bit fwr = bus_sel && bus_wr && bus_be[0] && (bus_addr == A_FLAGS);
        automatic bit frd = bus_sel && !bus_wr && (bus_addr == A_FLAGS);
        if (hit) begin
          m_cnt[i] <= 16'h0; m_duty[i] <= m_buf[i]; m_out[i] <= (m_buf[i] != 16'h0);
        end else begin
          if (cnt_run) m_cnt[i] <= m_cnt[i] + 16'h1;
          if (cnt_run && m_cnt[i] == m_duty[i]) m_out[i] <= 1'b0;
        end
        if (hit) m_flag[i] <= 1'b1;
        else if (fwr && m_arm[i] && !bus_wdata[i]) m_flag[i] <= 1'b0;
        if (frd) m_arm[i] <= m_flag[i];
        else if (fwr) m_arm[i] <= 1'b0;
        if (bus_sel && bus_wr && bus_be == 2'b11) begin
          if (bus_addr == 4'(i)) m_cyc[i] <= bus_wdata;
          if (bus_addr == 4'(i + NCH)) m_buf[i] <= bus_wdata;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    cnt_run = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 2'b11;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic count_high(input int ch, input int n, output int highs);
    highs = 0;
    for (int j = 0; j < n; j++) begin
      if (pwm_out[ch]) highs++;
      @(negedge clk);
    end
  endtask

  task automatic run_cmp(input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) check(tag, 16'(pwm_out[i]), 16'(m_out[i]));
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] d;
    do_reset();
    check("R1 outputs after reset", 16'(pwm_out), 16'h0);
    for (int i = 0; i < NCH; i++) begin
      bus_read(4'(i), d);       check("R1 period reset value", d, 16'hFFFF);
      bus_read(4'(i + NCH), d); check("R1 buffer reset value", d, 16'hFFFF);
    end
    bus_read(A_FLAGS, d); check("R1 flags after reset", d, 16'h0);
  endtask

  task automatic t_readwrite();
    logic [15:0] d;
    do_reset();
    for (int i = 0; i < NCH; i++) begin
      bus_write(4'(i), 16'h0100 + 16'(i), 2'b11);
      bus_write(4'(i + NCH), 16'hA500 + 16'(i), 2'b11);
    end
    for (int i = 0; i < NCH; i++) begin
      bus_read(4'(i), d);       check("R2 period readback", d, 16'h0100 + 16'(i));
      bus_read(4'(i + NCH), d); check("R2 buffer readback", d, 16'hA500 + 16'(i));
    end
    bus_read(4'd9, d);  check("R2 unmapped address", d, 16'h0);
    bus_read(4'd15, d); check("R2 unmapped address top", d, 16'h0);
  endtask

  task automatic t_partial_ignored();
    logic [15:0] d;
    do_reset();
    bus_write(4'd0, 16'h1234, 2'b01);
    bus_write(4'd5, 16'h5678, 2'b10);
    bus_write(4'd2, 16'h0000, 2'b00);
    bus_read(4'd0, d); check("R3 low-byte write ignored", d, 16'hFFFF);
    bus_read(4'd5, d); check("R3 high-byte write ignored", d, 16'hFFFF);
    bus_read(4'd2, d); check("R3 empty enable ignored", d, 16'hFFFF);
  endtask

  task automatic t_hold_count();
    logic [15:0] d;
    do_reset();
    bus_write(4'd0, 16'd4, 2'b11);
    cnt_run = 1'b1; repeat (3) @(negedge clk); cnt_run = 1'b0;
    repeat (10) @(negedge clk);
    bus_read(A_FLAGS, d); check("R4 no match while held", d & 16'h1, 16'h0);
    cnt_run = 1'b1; @(negedge clk); cnt_run = 1'b0;
    bus_read(A_FLAGS, d); check("R4 count reaches 4 not past", d & 16'h1, 16'h0);
    check("R4 output still reset level", 16'(pwm_out[0]), 16'h0);
    cnt_run = 1'b1; @(negedge clk); cnt_run = 1'b0;
    bus_read(A_FLAGS, d); check("R5 flag set at match", d & 16'h1, 16'h1);
    check("R7 output high after match with nonzero buffer", 16'(pwm_out[0]), 16'h1);
  endtask

  task automatic t_duty_window();
    int h;
    do_reset();
    bus_write(4'd2, 16'd9, 2'b11);
    bus_write(4'd6, 16'd3, 2'b11);
    cnt_run = 1'b1;
    count_high(2, 10, h); check("R8 low before first match", 16'(h), 16'd0);
    count_high(2, 10, h); check("R8 high time duty+1", 16'(h), 16'd4);
    count_high(2, 10, h); check("R8 high time second period", 16'(h), 16'd4);
    cnt_run = 1'b0;
  endtask

  task automatic t_zero_buffer();
    int h;
    do_reset();
    bus_write(4'd1, 16'd7, 2'b11);
    bus_write(4'd5, 16'd0, 2'b11);
    cnt_run = 1'b1;
    count_high(1, 7, h); check("R7 low before match", 16'(h), 16'd0);
    bus_write(4'd5, 16'd5, 2'b11);   // lands on the match edge
    count_high(1, 8, h); check("R7 zero buffer keeps period low", 16'(h), 16'd0);
    count_high(1, 8, h); check("R6 new buffer used at next match", 16'(h), 16'd6);
    cnt_run = 1'b0;
  endtask

  task automatic t_full_duty();
    int h;
    do_reset();
    bus_write(4'd3, 16'd10, 2'b11);
    cnt_run = 1'b1;
    count_high(3, 11, h); check("R1 output low until first match", 16'(h), 16'd0);
    count_high(3, 22, h); check("R1 reset duty keeps output high", 16'(h), 16'd22);
    cnt_run = 1'b0;
  endtask

  task automatic t_flag_clear();
    logic [15:0] d;
    do_reset();
    bus_write(4'd0, 16'd3, 2'b11);
    cnt_run = 1'b1; repeat (4) @(negedge clk); cnt_run = 1'b0;
    bus_write(A_FLAGS, 16'h0000, 2'b11);
    bus_read(A_FLAGS, d); check("R9 clear without read ignored", d, 16'h0001);
    bus_write(A_FLAGS, 16'hFFFF, 2'b11);
    bus_read(A_FLAGS, d); check("R9 writing one has no effect", d, 16'h0001);
    bus_write(A_FLAGS, 16'h0000, 2'b11);
    bus_read(A_FLAGS, d); check("R9 read then write zero clears", d, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    do_reset();
    bus_write(4'd0, 16'd5, 2'b11);
    cnt_run = 1'b1;
    while (!m_flag[0]) @(negedge clk);
    bus_read(A_FLAGS, d); check("R5 flag seen while running", d & 16'h1, 16'h1);
    while (m_cnt[0] != 16'd5) @(negedge clk);
    bus_write(A_FLAGS, 16'h0000, 2'b11);
    cnt_run = 1'b0;
    bus_read(A_FLAGS, d); check("R10 match beats clear", d & 16'h1, 16'h1);
    bus_write(A_FLAGS, 16'h0000, 2'b11);
    bus_read(A_FLAGS, d); check("R9 clear after re-read", d & 16'h1, 16'h0);
  endtask

  task automatic t_independent();
    do_reset();
    bus_write(4'd0, 16'd6, 2'b11);  bus_write(4'd4, 16'd2, 2'b11);
    bus_write(4'd1, 16'd9, 2'b11);  bus_write(4'd5, 16'd0, 2'b11);
    bus_write(4'd2, 16'd13, 2'b11); bus_write(4'd6, 16'd7, 2'b11);
    bus_write(4'd3, 16'd20, 2'b11); bus_write(4'd7, 16'd25, 2'b11);
    cnt_run = 1'b1;
    run_cmp(60, "R11 channel outputs vs reference");
    cnt_run = 1'b0; run_cmp(5, "R4 outputs frozen while held");
    cnt_run = 1'b1; run_cmp(40, "R8 duty compare vs reference");
    cnt_run = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_readwrite();
    t_partial_ignored();
    t_hold_count();
    t_duty_window();
    t_zero_buffer();
    t_full_duty();
    t_flag_clear();
    t_set_wins();
    t_independent();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule